// File: doc/BRIEF.md
# Reloading 16-bit Down-Counter with Reload Latch

This block is a memory-mapped down-counter for a small 8-bit processor bus. It pairs a 16-bit count register with a 16-bit reload latch. Software loads the latch one byte at a time. When the count steps down past zero, the counter takes the latch value back in instead of rolling over to all ones. That wrap also raises an overflow flag, and the flag can drive an interrupt request through an enable bit.

A 2-bit mode field picks what makes the counter step:
- Interval timing and pulse generation both count a clock-enable tick. In pulse generation an output pin also flips on every wrap.
- Event counting counts synchronized rising edges on the counter input pin.
- Pulse width measurement counts ticks only while the synchronized input pin is low.

One bus offset does two jobs. It writes the upper latch byte, and in the same cycle it loads the whole counter from the updated latch. This gives software a one-store preset.

Top module: `cnt_latch_top`

## Requirements
- R1: After reset the counter, the latch, the mode (00), the interrupt enable and the overflow flag are all 0, and `cnt_pin_out` and `irq_cnt` are low.
- R2: A write to offset 0x84 sets the upper latch byte and a write to offset 0x85 sets the lower latch byte. Reads of either offset return 0. A latch write alone leaves the counter unchanged.
- R3: Reading offset 0x86 returns the counter's upper byte and reading offset 0x87 returns its lower byte. Reads never alter the count. `bus_rdata` is 0 while `bus_rd` is low.
- R4: A write to offset 0x86 stores the data into the upper latch byte and, in the same clock, loads the counter with {data, lower latch byte}. This preset takes precedence over a count step in that cycle.
- R5: A count step from 0x0000 loads the counter with the latch value, not 0xFFFF, and sets the overflow flag.
- R6: The control register at offset 0x8F holds the mode in bits 1:0 and the counter interrupt enable in bit 4. Bit 7 reads the overflow flag and ignores writes. All other bits read 0.
- R7: `irq_cnt` is high exactly when the overflow flag and the interrupt enable are both 1.
- R8: In mode 00 (interval timer) the counter steps down once per cycle with `tick` high.
- R9: In mode 01 (pulse generator) the counter steps once per `tick`, and `cnt_pin_out` toggles on every wrap. In all other modes `cnt_pin_out` holds its value.
- R10: In mode 10 (event counter) the counter steps once per rising edge of `cnt_pin_in`, after a two-stage synchronizer, and ignores `tick`.
- R11: In mode 11 (pulse width measurement) the counter steps once per `tick` only while the synchronized `cnt_pin_in` is low.
- R12: Any write to offset 0x88 clears the overflow flag. If a wrap occurs in the same cycle as that write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock-enable tick for the timing modes |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| cnt_pin_in | input | 1 | External counter pin (asynchronous) |
| cnt_pin_out | output | 1 | Pulse generator output |
| irq_cnt | output | 1 | Counter interrupt request |

## Verification
The bench uses the default parameters: an 8-bit bus, which gives a 16-bit counter, and a two-stage pin synchronizer. With these values a latch of 0 to 7 wraps within a handful of ticks. That makes a full sweep of wrap intervals, reload values, flag setting and interrupt gating practical. A single long countdown from 0x12CD crosses every byte borrow and reaches a reload whose upper byte came from the preset offset. Fixed pin patterns in the event and pulse-width modes give exact step counts despite the synchronizer delay.

// File: rtl/cnt_pkg.sv
// Shared types for the reloading down-counter.
package cnt_pkg;
    // Count-source selection carried in control bits 1:0.
    typedef enum logic [1:0] {
        MODE_TIMER    = 2'b00,
        MODE_PULSEGEN = 2'b01,
        MODE_EVENT    = 2'b10,
        MODE_WIDTH    = 2'b11
    } cnt_mode_e;
endpackage

// File: rtl/cnt_pin_sync.sv
// Synchronizes the asynchronous counter pin and flags its rising edges.
// Assumes STAGES >= 2. The pin idles high, so every flop resets to 1
// and no edge is reported out of reset.
module cnt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // Shift the pin through the synchronizer chain and keep one old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cnt_enable.sv
// Picks the per-cycle count enable from the mode field.
// Assumes level and rise are already synchronous to clk.
module cnt_enable
    import cnt_pkg::*;
(
    input  cnt_mode_e mode,
    input  logic      tick,
    input  logic      level,
    input  logic      rise,
    output logic      en
);
    // Map each mode to its count source.
    always_comb begin
        case (mode)
            MODE_TIMER, MODE_PULSEGEN: en = tick;
            MODE_EVENT:                en = rise;
            MODE_WIDTH:                en = tick & ~level;
            default:                   en = 1'b0;
        endcase
    end
endmodule

// File: rtl/cnt_core.sv
// Counter, reload latch and overflow flag.
// Assumes the strobes are one-hot. The preset strobe also writes the upper
// latch byte. A preset overrides a count step, and a wrap overrides a clear.
module cnt_core #(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_latch_hi,
    input  logic          wr_latch_lo,
    input  logic          wr_preset,
    input  logic [DW-1:0] wdata,
    input  logic          en,
    input  logic          clr,
    output logic [CW-1:0] cnt_q,
    output logic          wrap,
    output logic          ovf_q
);
    logic [CW-1:0] latch_q;

    assign wrap = en & ~wr_preset & (cnt_q == '0);

    // Byte-wise latch updates; the preset offset also writes the upper byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            if (wr_latch_hi || wr_preset) latch_q[CW-1:DW] <= wdata;
            if (wr_latch_lo)              latch_q[DW-1:0]  <= wdata;
        end
    end

    // Preset from the latch, otherwise step down or reload on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_preset) begin
            cnt_q <= {wdata, latch_q[DW-1:0]};
        end else if (en) begin
            if (cnt_q == '0) cnt_q <= latch_q;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Overflow flag: set on wrap, cleared by the clear strobe, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (wrap) ovf_q <= 1'b1;
        else if (clr)  ovf_q <= 1'b0;
    end
endmodule

// File: rtl/cnt_latch_top.sv
// Bus-attached reloading down-counter: address decode, control register,
// read-back mux, pulse output and interrupt. Assumes DW >= 8 so that the
// control bit positions exist, and a one-cycle write strobe.
module cnt_latch_top
    import cnt_pkg::*;
#(
    parameter int DW           = 8,
    parameter int AW           = 8,
    parameter int OFF_LATCH_HI = 'h84,
    parameter int OFF_LATCH_LO = 'h85,
    parameter int OFF_CNT_HI   = 'h86,
    parameter int OFF_CNT_LO   = 'h87,
    parameter int OFF_CLEAR    = 'h88,
    parameter int OFF_CTRL     = 'h8F,
    parameter int SYNC_STAGES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          cnt_pin_in,
    output logic          cnt_pin_out,
    output logic          irq_cnt
);
    localparam int          CW      = 2 * DW;
    localparam int          BIT_OVF = 7;
    localparam int          BIT_IE  = 4;
    localparam logic [AW-1:0] A_LHI = AW'(OFF_LATCH_HI);
    localparam logic [AW-1:0] A_LLO = AW'(OFF_LATCH_LO);
    localparam logic [AW-1:0] A_CHI = AW'(OFF_CNT_HI);
    localparam logic [AW-1:0] A_CLO = AW'(OFF_CNT_LO);
    localparam logic [AW-1:0] A_CLR = AW'(OFF_CLEAR);
    localparam logic [AW-1:0] A_CTL = AW'(OFF_CTRL);

    cnt_mode_e     mode_q;
    logic          ie_q;
    logic          pin_out_q;
    logic          pin_level, pin_rise, en, wrap, ovf_q;
    logic          wr_latch_hi, wr_latch_lo, wr_preset, clr;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rd_mux;

    assign wr_latch_hi = bus_wr && (bus_addr == A_LHI);
    assign wr_latch_lo = bus_wr && (bus_addr == A_LLO);
    assign wr_preset   = bus_wr && (bus_addr == A_CHI);
    assign clr         = bus_wr && (bus_addr == A_CLR);

    cnt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cnt_pin_in),
        .level (pin_level),
        .rise  (pin_rise)
    );

    cnt_enable u_en (
        .mode  (mode_q),
        .tick  (tick),
        .level (pin_level),
        .rise  (pin_rise),
        .en    (en)
    );

    cnt_core #(.DW(DW), .CW(CW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_latch_hi (wr_latch_hi),
        .wr_latch_lo (wr_latch_lo),
        .wr_preset   (wr_preset),
        .wdata       (bus_wdata),
        .en          (en),
        .clr         (clr),
        .cnt_q       (cnt_q),
        .wrap        (wrap),
        .ovf_q       (ovf_q)
    );

    // Control register: mode field and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_TIMER;
            ie_q   <= 1'b0;
        end else if (bus_wr && (bus_addr == A_CTL)) begin
            mode_q <= cnt_mode_e'(bus_wdata[1:0]);
            ie_q   <= bus_wdata[BIT_IE];
        end
    end

    // Pulse output flips on each wrap in pulse generator mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pin_out_q <= 1'b0;
        else if (wrap && mode_q == MODE_PULSEGEN) pin_out_q <= ~pin_out_q;
    end

    // Read-back mux; latch and clear offsets read as zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_CHI: rd_mux = cnt_q[CW-1:DW];
            A_CLO: rd_mux = cnt_q[DW-1:0];
            A_CTL: begin
                rd_mux[1:0]     = mode_q;
                rd_mux[BIT_IE]  = ie_q;
                rd_mux[BIT_OVF] = ovf_q;
            end
            default: rd_mux = '0;
        endcase
    end

    assign bus_rdata   = bus_rd ? rd_mux : '0;
    assign cnt_pin_out = pin_out_q;
    assign irq_cnt     = ovf_q & ie_q;
endmodule

// File: rtl/cnt_checker.sv
// Temporal checks for cnt_latch_top, attached by the bind below.
module cnt_checker #(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          wr_preset,
    input logic          wrap,
    input logic          clr,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] latch,
    input logic          ovf,
    input logic          ie,
    input logic          irq,
    input logic [1:0]    mode,
    input logic          pin_out,
    input logic [DW-1:0] wdata
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    // R8: a step from a non-zero count subtracts one.
    a_r8_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_preset && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    // R5: a step from zero reloads the latch value.
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_preset && cnt == '0) |=> (cnt == $past(latch)));

    // R5: a step from zero sets the overflow flag.
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_preset && cnt == '0) |=> ovf);

    // R4: the preset loads the written byte over the lower latch byte.
    a_r4_preset: assert property (@(posedge clk) disable iff (!rst_n)
        wr_preset |=> (cnt == {$past(wdata), $past(latch[DW-1:0])}));

    // R3: without a step or a preset, reads and other writes leave the count alone.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_preset) |=> $stable(cnt));

    // R7: with the enable off there is never an interrupt request.
    a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);

    // R12: a clear without a simultaneous wrap leaves the flag low.
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wrap) |=> !ovf);

    // R9: the output pin flips on a wrap in pulse generator mode.
    a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode == 2'b01) |=> (pin_out != $past(pin_out)));

    // R9: the output pin holds at all other times.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrap && mode == 2'b01) |=> $stable(pin_out));
endmodule

bind cnt_latch_top cnt_checker #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .wr_preset (wr_preset),
    .wrap      (wrap),
    .clr       (clr),
    .cnt       (cnt_q),
    .latch     (u_core.latch_q),
    .ovf       (ovf_q),
    .ie        (ie_q),
    .irq       (irq_cnt),
    .mode      (mode_q),
    .pin_out   (cnt_pin_out),
    .wdata     (bus_wdata)
);

// File: tb/sim_cnt_latch_top.sv
// Self-checking bench for cnt_latch_top with its default parameters.
module sim_cnt_latch_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_pin_in = 1'b1;
    logic       cnt_pin_out;
    logic       irq_cnt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cnt_latch_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_pin_in  (cnt_pin_in),
        .cnt_pin_out (cnt_pin_out),
        .irq_cnt     (irq_cnt)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] hi, lo;
        brd(8'h86, hi);
        brd(8'h87, lo);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic preset(input logic [15:0] v);
        bwr(8'h85, v[7:0]);
        bwr(8'h86, v[15:8]);
    endtask

    task automatic setctrl(input logic [1:0] m, input logic ie);
        bwr(8'h8F, {3'b000, ie, 2'b00, m});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, w;
        logic [7:0]  b;
        logic        pin0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd16(v);            check("R1 counter", v, 16'h0000);
        brd(8'h8F, b);      check("R1 control", {8'h00, b}, 16'h0000);
        check("R1 irq", {15'b0, irq_cnt}, 16'h0000);
        check("R1 pin_out", {15'b0, cnt_pin_out}, 16'h0000);
        check("R3 rdata idle", {8'h00, bus_rdata}, 16'h0000);
        ticks(1);           // wrap from 0 reloads the reset latch (0)
        rd16(v);            check("R1/R5 latch reset reload", v, 16'h0000);
        brd(8'h8F, b);      check("R5 ovf set", {8'h00, b}, 16'h0080);
        check("R9 pin holds in mode 00", {15'b0, cnt_pin_out}, 16'h0000);
        bwr(8'h88, 8'h00);
        brd(8'h8F, b);      check("R12 clear", {8'h00, b}, 16'h0000);

        // R2/R4: latch bytes and preset
        bwr(8'h84, 8'hAB);
        bwr(8'h85, 8'hCD);
        rd16(v);            check("R2 latch write keeps counter", v, 16'h0000);
        brd(8'h84, b);      check("R2 latch hi reads 0", {8'h00, b}, 16'h0000);
        brd(8'h85, b);      check("R2 latch lo reads 0", {8'h00, b}, 16'h0000);
        bwr(8'h86, 8'h12);
        rd16(v);            check("R4 preset", v, 16'h12CD);
        bwr(8'h85, 8'h00);  // latch now 0x1200
        ticks(16'h12CD);
        rd16(v);            check("R8 long countdown", v, 16'h0000);
        brd(8'h8F, b);      check("R5 no early flag", {8'h00, b}, 16'h0000);
        ticks(1);
        rd16(v);            check("R4/R5 reload upper from preset", v, 16'h1200);
        brd(8'h8F, b);      check("R5 flag after wrap", {8'h00, b}, 16'h0080);

        // R3: reads do not alter the count
        bwr(8'h88, 8'h00);
        rd16(v); rd16(w);   check("R3 repeated reads stable", w, v);
        ticks(3);
        rd16(v);            check("R3 count after reads", v, 16'h11FD);
        preset(16'h0100);
        ticks(1);
        rd16(v);            check("R8 borrow across bytes", v, 16'h00FF);

        // R8/R5/R7: sweep of small reload values in interval mode
        setctrl(2'b00, 1'b1);
        for (int l = 0; l < 8; l++) begin
            preset(16'(l));
            bwr(8'h88, 8'h00);
            ticks(l);
            check($sformatf("R8 no irq before wrap L=%0d", l), {15'b0, irq_cnt}, 16'h0000);
            ticks(1);
            check($sformatf("R7 irq at wrap L=%0d", l), {15'b0, irq_cnt}, 16'h0001);
            rd16(v);
            check($sformatf("R5 reload L=%0d", l), v, 16'(l));
        end

        // R6/R7: control register fields and masking
        bwr(8'h8F, 8'h6C);
        brd(8'h8F, b);      check("R6 unused bits read 0", {8'h00, b}, 16'h0080);
        check("R7 masked irq", {15'b0, irq_cnt}, 16'h0000);
        bwr(8'h8F, 8'hFF);
        brd(8'h8F, b);      check("R6 all fields", {8'h00, b}, 16'h0093);
        check("R7 irq enabled", {15'b0, irq_cnt}, 16'h0001);

        // R12: clear and same-cycle set
        setctrl(2'b00, 1'b1);
        bwr(8'h88, 8'h00);
        check("R12 clear drops irq", {15'b0, irq_cnt}, 16'h0000);
        preset(16'h0000);
        @(negedge clk);
        bus_addr = 8'h88; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        brd(8'h8F, b);      check("R12 set wins over clear", {8'h00, b}, 16'h0090);
        bwr(8'h88, 8'h00);

        // R9: pulse generator toggling
        setctrl(2'b01, 1'b0);
        preset(16'h0002);
        pin0 = cnt_pin_out;
        ticks(3);
        check("R9 toggle 1", {15'b0, cnt_pin_out}, {15'b0, ~pin0});
        ticks(3);
        check("R9 toggle 2", {15'b0, cnt_pin_out}, {15'b0, pin0});
        ticks(2);
        check("R9 no toggle mid-count", {15'b0, cnt_pin_out}, {15'b0, pin0});
        ticks(1);
        check("R9 toggle 3", {15'b0, cnt_pin_out}, {15'b0, ~pin0});

        // R10: event counter, tick held high and ignored
        setctrl(2'b10, 1'b0);
        preset(16'h0010);
        @(negedge clk); tick = 1'b1;
        for (int e = 0; e < 5; e++) begin
            @(negedge clk); cnt_pin_in = 1'b0;
            repeat (3) @(negedge clk);
            cnt_pin_in = 1'b1;
            repeat (3) @(negedge clk);
        end
        tick = 1'b0;
        repeat (3) @(negedge clk);
        rd16(v);            check("R10 five rising edges", v, 16'h000B);

        // R11: pulse width measurement
        setctrl(2'b11, 1'b0);
        preset(16'h0100);
        @(negedge clk); cnt_pin_in = 1'b0;
        repeat (4) @(negedge clk);
        cnt_pin_in = 1'b1;
        repeat (4) @(negedge clk);
        rd16(v);            check("R11 low pin without tick", v, 16'h0100);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        cnt_pin_in = 1'b0;
        repeat (5) @(negedge clk);
        cnt_pin_in = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        rd16(v);            check("R11 five low cycles", v, 16'h00FB);
        check("R9 pin holds in mode 11", {15'b0, cnt_pin_out}, {15'b0, ~pin0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule